// File: doc/BRIEF.md
# PCI DMA Window Translator

This block turns a 32-bit PCI DMA address into a 35-bit system physical address. Four programmable windows each decide whether an address belongs to them: a window has a base, a size mask that sets which upper address bits act as offset, and a translated base. A window maps in one of two ways. In direct mode the physical address is built in one step. In scatter-gather mode the block reads an 8-byte page entry from system memory and builds the address from that entry.

A requester presents one PCI address with a valid strobe whenever `req_ready_o` is high. The block returns one result carrying a hit flag and the physical address. A direct translation, and any miss, returns one cycle after it is accepted. A scatter-gather translation raises a single-cycle page-entry read and returns one cycle after the memory response. Only one translation is in flight at a time. A global control bit can exclude a fixed legacy hole (0x80000 to 0xFFFFF) from all windows.

Top module: `dma_win_xlat`

## Requirements
- R1: After reset `req_ready_o` is 1 and `res_valid_o` and `mem_req_o` are 0. Every window starts disabled, so any request misses.
- R2: A window hits when its enable bit (bit 0 of its base register) is set and PCI address bits 31:20 equal base bits 31:20 at every position where mask bits 31:20 are 0. A miss returns `res_hit_o`=0 with `res_addr_o`=0.
- R3: When several windows hit, the result uses the window with the lowest index.
- R4: In direct mode the result address bits 19:0 are PCI bits 19:0. Each of bits 34:20 is taken from the PCI address where the corresponding mask bit is 1 and from translated-base bits 34:20 where it is 0. Mask bits above 31 count as 0.
- R5: A direct translation or a miss sets `res_valid_o` for one cycle, in the cycle after acceptance, and issues no memory read. Back-to-back requests are accepted on consecutive cycles.
- R6: A hit on a window whose scatter-gather bit (bit 1 of its base register) is set raises `mem_req_o` for exactly one cycle, in the cycle after acceptance. The page-entry address is translated-base bits 34:10 ORed with (PCI address AND (mask bits 31:20 plus bits 19:13)) shifted right by 10.
- R7: The scatter-gather result is valid in the cycle after `mem_rsp_valid_i`. The address is (entry shifted left by 12, limited to bits 34:13) ORed with PCI bits 12:0.
- R8: If bit 0 of the returned page entry is 0, the scatter-gather result is a miss.
- R9: `req_ready_o` is 0 from the cycle after a scatter-gather acceptance until the cycle its result is valid.
- R10: While control bit 5 is set, PCI addresses 0x80000 to 0xFFFFF miss in every window. Addresses 0x7FFFF and 0x100000 are not affected. While the bit is clear, those addresses translate normally.
- R11: CSR writes use `csr_addr_i[1:0]` for the register kind (0 base, 1 mask, 2 translated base, 3 control) and `csr_addr_i[3:2]` for the window. For the control kind the window bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 4 | Window index [3:2] and register kind [1:0] |
| csr_wdata_i | input | 35 | CSR write data |
| req_valid_i | input | 1 | Translation request valid |
| req_addr_i | input | 32 | PCI DMA address |
| req_ready_o | output | 1 | Block can accept a request |
| res_valid_o | output | 1 | Result valid, one cycle |
| res_hit_o | output | 1 | Translation hit |
| res_addr_o | output | 35 | Physical address, 0 on miss |
| mem_req_o | output | 1 | Page-entry read strobe |
| mem_addr_o | output | 35 | Page-entry address |
| mem_rsp_valid_i | input | 1 | Page-entry read data valid |
| mem_rdata_i | input | 64 | Page-entry data |

## Verification
Several address patterns are sent.
- Addresses inside and just outside a window separate the mask comparison from the base comparison.
- Overlapping windows, first with the lower window enabled and then with it disabled, show that priority is resolved by index and not by order.
- Scatter-gather requests with a zero mask and with a wider mask show whether the index is extended by the mask. Valid and invalid page entries distinguish R7 from R8.
- Hole probes at 0x7FFFF, 0x80000, 0xFFFFF and 0x100000, sent with the control bit set and then cleared, pin both hole edges and confirm the hole can be turned off.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
  localparam int PCI_W  = 32;
  localparam int PA_W   = 35;
  localparam int PTE_W  = 64;
  localparam int WIN_LSB = 20;               // minimum window = 1 MB
  localparam int TB_LSB  = 10;               // page-entry table alignment
  localparam int PG_LSB  = 13;               // 8 KB pages
  localparam int WF_W   = PCI_W - WIN_LSB;   // compared address bits
  localparam int TB_W   = PA_W - TB_LSB;     // stored translated-base bits
  localparam int HI_W   = PA_W - WIN_LSB;    // direct-mode upper bits

  localparam logic [WIN_LSB-1:0] SG_IDX_MASK = 20'hFE000; // bits 19:13
  localparam logic [PCI_W-1:0]   HOLE_LO = 32'h0008_0000;
  localparam logic [PCI_W-1:0]   HOLE_HI = 32'h000F_FFFF;
  localparam int HOLE_BIT = 5;
  localparam int EN_BIT   = 0;
  localparam int SG_BIT   = 1;

  localparam logic [1:0] K_BASE  = 2'd0;
  localparam logic [1:0] K_MASK  = 2'd1;
  localparam logic [1:0] K_TBASE = 2'd2;
  localparam logic [1:0] K_CTRL  = 2'd3;

  typedef struct packed {
    logic [WF_W-1:0] addr;
    logic            sg;
    logic            en;
  } win_base_t;

  typedef struct packed {
    win_base_t       base;
    logic [WF_W-1:0] mask;
    logic [TB_W-1:0] tbase;   // physical bits 34:10
  } win_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} xl_state_t;
endpackage

// File: rtl/dwx_csr.sv
module dwx_csr
  import dwx_pkg::*;
#(
  parameter int N_WIN = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [$clog2(N_WIN)+1:0]   addr_i,
  input  logic [PA_W-1:0]            wdata_i,
  output win_cfg_t [N_WIN-1:0]       cfg_o,
  output logic                       hole_en_o
);
  localparam int IW = $clog2(N_WIN);

  logic [1:0]    kind;
  logic [IW-1:0] widx;
  assign kind = addr_i[1:0];
  assign widx = addr_i[IW+1:2];

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[9:6], wdata_i[4:2]};

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[g] <= '0;
      end else if (we_i && widx == IW'(g)) begin
        case (kind)
          K_BASE: begin
            cfg_o[g].base.addr <= wdata_i[PCI_W-1:WIN_LSB];
            cfg_o[g].base.sg   <= wdata_i[SG_BIT];
            cfg_o[g].base.en   <= wdata_i[EN_BIT];
          end
          K_MASK:  cfg_o[g].mask  <= wdata_i[PCI_W-1:WIN_LSB];
          K_TBASE: cfg_o[g].tbase <= wdata_i[PA_W-1:TB_LSB];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       hole_en_o <= 1'b0;
    else if (we_i && kind == K_CTRL)   hole_en_o <= wdata_i[HOLE_BIT];
  end

  // R11: control write lands regardless of window index bits
  p_ctrl_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind == K_CTRL) |=> (hole_en_o == $past(wdata_i[HOLE_BIT])));
endmodule

// File: rtl/dwx_match.sv
module dwx_match
  import dwx_pkg::*;
#(
  parameter int N_WIN = 4
) (
  input  win_cfg_t [N_WIN-1:0] cfg_i,
  input  logic                 hole_en_i,
  input  logic [PCI_W-1:0]     addr_i,
  output logic                 hit_o,
  output logic                 sg_o,
  output logic [PA_W-1:0]      dm_pa_o,
  output logic [PA_W-1:0]      pte_addr_o
);
  localparam int IW = $clog2(N_WIN);

  logic [N_WIN-1:0] win_hit;
  logic             in_hole;
  logic [IW-1:0]    sel;
  win_cfg_t         sc;

  for (genvar g = 0; g < N_WIN; g++) begin : g_cmp
    assign win_hit[g] = cfg_i[g].base.en &&
      (((addr_i[PCI_W-1:WIN_LSB] ^ cfg_i[g].base.addr) & ~cfg_i[g].mask) == '0);
  end

  assign in_hole = hole_en_i && (addr_i >= HOLE_LO) && (addr_i <= HOLE_HI);

  // lowest index wins: scan downward so the last write is the lowest hit
  always_comb begin
    sel = '0;
    for (int i = N_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) sel = IW'(i);
    end
  end

  assign sc    = cfg_i[sel];
  assign hit_o = (|win_hit) && !in_hole;
  assign sg_o  = sc.base.sg;

  logic [HI_W-1:0]  tb_hi, msk_x, adr_x;
  logic [PCI_W-1:0] sg_idx;

  assign tb_hi = sc.tbase[TB_W-1:WIN_LSB-TB_LSB];
  assign msk_x = HI_W'(sc.mask);
  assign adr_x = HI_W'(addr_i[PCI_W-1:WIN_LSB]);

  assign dm_pa_o = {(tb_hi & ~msk_x) | (adr_x & msk_x), addr_i[WIN_LSB-1:0]};

  assign sg_idx     = addr_i & {sc.mask, SG_IDX_MASK};
  assign pte_addr_o = {sc.tbase, {TB_LSB{1'b0}}} | PA_W'(sg_idx >> TB_LSB);
endmodule

// File: rtl/dma_win_xlat.sv
module dma_win_xlat
  import dwx_pkg::*;
#(
  parameter int N_WIN = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     csr_we_i,
  input  logic [$clog2(N_WIN)+1:0] csr_addr_i,
  input  logic [PA_W-1:0]          csr_wdata_i,
  input  logic                     req_valid_i,
  input  logic [PCI_W-1:0]         req_addr_i,
  output logic                     req_ready_o,
  output logic                     res_valid_o,
  output logic                     res_hit_o,
  output logic [PA_W-1:0]          res_addr_o,
  output logic                     mem_req_o,
  output logic [PA_W-1:0]          mem_addr_o,
  input  logic                     mem_rsp_valid_i,
  input  logic [PTE_W-1:0]         mem_rdata_i
);
  win_cfg_t [N_WIN-1:0] cfg;
  logic                 hole_en;
  logic                 hit, sg;
  logic [PA_W-1:0]      dm_pa, pte_addr;

  dwx_csr #(.N_WIN(N_WIN)) u_csr (
    .clk_i, .rst_ni,
    .we_i(csr_we_i), .addr_i(csr_addr_i), .wdata_i(csr_wdata_i),
    .cfg_o(cfg), .hole_en_o(hole_en)
  );

  dwx_match #(.N_WIN(N_WIN)) u_match (
    .cfg_i(cfg), .hole_en_i(hole_en), .addr_i(req_addr_i),
    .hit_o(hit), .sg_o(sg), .dm_pa_o(dm_pa), .pte_addr_o(pte_addr)
  );

  xl_state_t         st_q;
  logic [PG_LSB-1:0] pg_off_q;
  logic              accept;

  logic unused_pte;
  assign unused_pte = ^mem_rdata_i[PTE_W-1:PA_W-PG_LSB+1+PG_LSB-12];

  assign accept      = req_valid_i && req_ready_o;
  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_ISSUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_addr_o  <= '0;
      mem_addr_o  <= '0;
      pg_off_q    <= '0;
    end else begin
      res_valid_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          if (hit && sg) begin
            st_q       <= ST_ISSUE;
            mem_addr_o <= pte_addr;
            pg_off_q   <= req_addr_i[PG_LSB-1:0];
          end else begin
            res_valid_o <= 1'b1;
            res_hit_o   <= hit;
            res_addr_o  <= hit ? dm_pa : '0;
          end
        end
        default: begin
          if (mem_rsp_valid_i) begin
            st_q        <= ST_IDLE;
            res_valid_o <= 1'b1;
            res_hit_o   <= mem_rdata_i[0];
            // entry << 12 limited to bits 34:13 equals entry bits 22:1
            res_addr_o  <= mem_rdata_i[0] ?
                           {mem_rdata_i[PA_W-PG_LSB:1], pg_off_q} : '0;
          end else begin
            st_q <= ST_WAIT;
          end
        end
      endcase
    end
  end

  p_miss_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_addr_o == '0));

  p_quick_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (res_valid_o ^ mem_req_o));

  p_one_cycle_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_rsp_to_result_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && mem_rsp_valid_i) |=> (res_valid_o && req_ready_o));

  p_busy_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (!req_ready_o && !res_valid_o));
endmodule

// File: tb/dma_win_xlat_bench.sv
module dma_win_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [3:0]  csr_addr = '0;
  logic [34:0] csr_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        req_ready, res_valid, res_hit, mem_req;
  logic [34:0] res_addr, mem_addr;

  always #5 clk = ~clk;

  dma_win_xlat u_dma_win_xlat (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_we_i(csr_we), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .res_valid_o(res_valid), .res_hit_o(res_hit), .res_addr_o(res_addr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rdata_i(mem_rdata)
  );

  typedef struct { logic hit; logic [34:0] pa; int cyc; string tag; } sb_t;
  typedef struct { logic [34:0] addr; logic [63:0] data; string tag; } pte_t;
  sb_t  sb_q[$];
  pte_t pte_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [34:0] f_base(input logic [11:0] a, input bit sg, input bit en);
    return (35'(a) << 20) | (35'(sg) << 1) | 35'(en);
  endfunction
  function automatic logic [34:0] f_direct(input logic [34:0] tb, input logic [11:0] m, input logic [31:0] a);
    logic [34:0] mx;
    mx = {3'b0, m, 20'hFFFFF};
    return (tb & ~mx & 35'h7_FFF0_0000) | (35'(a) & mx);
  endfunction
  function automatic logic [34:0] f_pte_addr(input logic [34:0] tb, input logic [11:0] m, input logic [31:0] a);
    return (tb & 35'h7_FFFF_FC00) | 35'((a & {m, 20'hFE000}) >> 10);
  endfunction
  function automatic logic [34:0] f_sg(input logic [63:0] pte, input logic [31:0] a);
    return (35'(pte << 12) & 35'h7_FFFF_E000) | 35'(a[12:0]);
  endfunction

  task automatic wr(input logic [1:0] win, input logic [1:0] kind, input logic [34:0] d);
    csr_we = 1'b1; csr_addr = {win, kind}; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] a, input logic ehit, input logic [34:0] epa,
                      input bit is_sg, input logic [34:0] epte, input logic [63:0] pte, input string tag);
    sb_t it;
    pte_t p;
    while (!req_ready) @(negedge clk);
    if (is_sg) begin
      p.addr = epte; p.data = pte; p.tag = tag;
      pte_q.push_back(p);
    end
    it.hit = ehit; it.pa = ehit ? epa : '0; it.cyc = is_sg ? -1 : cyc + 1; it.tag = tag;
    sb_q.push_back(it);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (is_sg) chk(!req_ready, "R9 ready low while scatter-gather busy", 64'(req_ready), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R5 unexpected result", 64'(res_addr), 0);
      end else begin
        sb_t e;
        e = sb_q.pop_front();
        chk(res_hit == e.hit, {e.tag, " hit"}, 64'(res_hit), 64'(e.hit));
        chk(res_addr == e.pa, {e.tag, " addr"}, 64'(res_addr), 64'(e.pa));
        if (e.cyc >= 0) chk(cyc == e.cyc, "R5 result latency", 64'(cyc), 64'(e.cyc));
      end
    end
  end

  // page-entry memory model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        if (pte_q.size() == 0) begin
          chk(1'b0, "R5 unexpected memory read", 64'(mem_addr), 0);
        end else begin
          pte_t p;
          p = pte_q.pop_front();
          chk(mem_addr == p.addr, {p.tag, " R6 entry address"}, 64'(mem_addr), 64'(p.addr));
          @(negedge clk);
          chk(!mem_req, "R6 read strobe one cycle", 64'(mem_req), 0);
          @(negedge clk);
          mem_rsp_valid = 1'b1; mem_rdata = p.data;
          @(negedge clk);
          mem_rsp_valid = 1'b0; mem_rdata = '0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [34:0] tb1, tb2, tb3, tb0;
    tb1 = 35'h2_3450_0000; tb2 = 35'h6_7800_0000; tb3 = 35'h1_2345_6000; tb0 = 35'h5_0000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 1);
    chk(res_valid == 1'b0, "R1 no result after reset", 64'(res_valid), 0);
    chk(mem_req == 1'b0, "R1 no read after reset", 64'(mem_req), 0);
    send(32'h1234_5678, 0, 0, 0, 0, 0, "R1 reset windows miss");

    // R2 / R4 / R11: window 1 direct, 16 MB
    wr(2'd1, 2'd1, 35'(12'h00F) << 20);
    wr(2'd1, 2'd2, tb1);
    send(32'h1053_4567, 0, 0, 0, 0, 0, "R2 disabled window miss");
    wr(2'd1, 2'd0, f_base(12'h100, 0, 1));
    send(32'h1053_4567, 1, f_direct(tb1, 12'h00F, 32'h1053_4567), 0, 0, 0, "R4 direct in window");
    send(32'h10FF_FFFF, 1, f_direct(tb1, 12'h00F, 32'h10FF_FFFF), 0, 0, 0, "R2 window top edge");
    send(32'h1100_0000, 0, 0, 0, 0, 0, "R2 just outside window");

    // R3: window 2 overlaps window 1
    wr(2'd2, 2'd1, 35'(12'h0FF) << 20);
    wr(2'd2, 2'd2, tb2);
    wr(2'd2, 2'd0, f_base(12'h100, 0, 1));
    send(32'h1053_4567, 1, f_direct(tb1, 12'h00F, 32'h1053_4567), 0, 0, 0, "R3 lowest window wins");
    send(32'h1200_0040, 1, f_direct(tb2, 12'h0FF, 32'h1200_0040), 0, 0, 0, "R3 only upper window");
    wr(2'd1, 2'd0, f_base(12'h100, 0, 0));
    send(32'h1053_4567, 1, f_direct(tb2, 12'h0FF, 32'h1053_4567), 0, 0, 0, "R3 fallback after disable");

    // R5 back to back (both on consecutive cycles)
    send(32'h1300_0000, 1, f_direct(tb2, 12'h0FF, 32'h1300_0000), 0, 0, 0, "R5 back to back first");
    send(32'h2000_0000, 0, 0, 0, 0, 0, "R5 back to back second");

    // R6 / R7 / R8: window 3 scatter-gather
    wr(2'd3, 2'd1, '0);
    wr(2'd3, 2'd2, tb3);
    wr(2'd3, 2'd0, f_base(12'h800, 1, 1));
    send(32'h8005_A123, 1, f_sg(64'h0000_0000_0012_3457, 32'h8005_A123), 1,
         f_pte_addr(tb3, 12'h000, 32'h8005_A123), 64'h0000_0000_0012_3457, "R7 scatter-gather valid entry");
    send(32'h8005_A123, 0, 0, 1,
         f_pte_addr(tb3, 12'h000, 32'h8005_A123), 64'h0000_0000_0012_3456, "R8 invalid entry miss");
    wr(2'd3, 2'd1, 35'(12'h003) << 20);
    wr(2'd3, 2'd2, 35'h1_2340_0000);
    send(32'h8025_E010, 1, f_sg(64'h0000_0000_0055_AA01, 32'h8025_E010), 1,
         f_pte_addr(35'h1_2340_0000, 12'h003, 32'h8025_E010), 64'h0000_0000_0055_AA01, "R6 mask extends index");

    // R10 / R11: hole on window 0 (2 MB), ctrl written with window bits = 2
    wr(2'd0, 2'd1, 35'(12'h001) << 20);
    wr(2'd0, 2'd2, tb0);
    wr(2'd0, 2'd0, f_base(12'h000, 0, 1));
    wr(2'd2, 2'd3, 35'h20);
    send(32'h0008_0000, 0, 0, 0, 0, 0, "R10 hole low edge");
    send(32'h000F_FFFF, 0, 0, 0, 0, 0, "R10 hole high edge");
    send(32'h0007_FFFF, 1, f_direct(tb0, 12'h001, 32'h0007_FFFF), 0, 0, 0, "R10 below hole");
    send(32'h0010_0000, 1, f_direct(tb0, 12'h001, 32'h0010_0000), 0, 0, 0, "R10 above hole");
    wr(2'd0, 2'd3, 35'h0);
    send(32'h0008_0000, 1, f_direct(tb0, 12'h001, 32'h0008_0000), 0, 0, 0, "R11 R10 hole cleared");

    repeat (10) @(negedge clk);
    chk(sb_q.size() == 0, "R5 all results returned", 64'(sb_q.size()), 0);
    chk(pte_q.size() == 0, "R6 all reads issued", 64'(pte_q.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule